// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit maps 16-bit virtual addresses onto a 16-bit physical space through a four-entry segment table that it keeps internally. The two most significant address bits pick a segment and the lower fourteen bits are an offset into it. Each segment entry has four fields: a base address, a size limit in bytes, a valid flag and a read-only flag. A translation adds the base to the offset. It fails if any of three checks fails: the segment is not valid, the offset is at or beyond the limit, or the access is a store into a read-only segment.

A requester pulses a strobe with an address and a load/store flag. One cycle later the unit returns a response carrying the physical address, a fault code and a memory-enable qualifier. A separate configuration port rewrites table entries. It takes effect only while the kernel-mode qualifier is high. Writes made in user mode are dropped.

Top module: `seg_xlat_unit`

## Requirements
- R1: The segment index is vaddr[15:14] and the offset is vaddr[13:0]. A successful translation returns base + offset, truncated to 16 bits.
- R2: Each cycle with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle without a request gives `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_mem_en` all zero on the next cycle.
- R3: An offset equal to or greater than the segment limit gives fault code 2 (bounds).
- R4: An access to a segment whose valid flag is clear gives fault code 1 (invalid). This check takes priority over the bounds and protection checks.
- R5: A store (`req_write`=1) into a read-only segment gives fault code 3 (protection). Loads from a read-only segment succeed. Read-write segments accept both loads and stores. The bounds fault takes priority over the protection fault.
- R6: With fault code 0 (none), `rsp_mem_en` is 1. With any fault, `rsp_mem_en` is 0 and `rsp_paddr` is 0.
- R7: After reset the table holds the following entries, all valid. Segment 0: base 0x4000, limit 0x0800, read-only. Segment 1: base 0x4800, limit 0x1400, read-write. Segment 2: base 0xF000, limit 0x1000, read-write. Segment 3: base 0x0000, limit 0x3000, read-write.
- R8: A configuration write with `cfg_we` and `cfg_kernel` both high replaces entry `cfg_idx` at the clock edge. A request in the same cycle still sees the old entry. Requests from the next cycle on see the new one.
- R9: A configuration write with `cfg_kernel` low leaves the table unchanged.
- R10: While reset is asserted, and right after it, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_kernel | input | 1 | Kernel-mode qualifier for table writes |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 15 | New limit in bytes |
| cfg_valid | input | 1 | New valid flag |
| cfg_ronly | input | 1 | New read-only flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 16 | Physical address (zero on fault) |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |
| rsp_mem_en | output | 1 | Memory access may proceed |

## Verification
A corrupted table entry shows up on the first response that uses that segment, one cycle after the request. It appears either as a shifted physical address or as the wrong fault code. A wrong fault priority only shows when several checks fail at once, so the stimulus pairs invalid segments with out-of-range stores and out-of-range stores with read-only segments. A configuration write that leaks through in user mode, or that lands a cycle early or late, shows on the following request to that entry. For that reason, requests run alongside table writes.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int ADDR_W  = 16;
  localparam int SEG_W   = 2;
  localparam int OFF_W   = ADDR_W - SEG_W;
  localparam int LIM_W   = OFF_W + 1;
  localparam int N_SEG   = 1 << SEG_W;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              valid;
    logic              ronly;
  } seg_entry_t;

  function automatic seg_entry_t seg_reset_entry(input int idx);
    seg_entry_t e;
    e.valid = 1'b1;
    e.ronly = 1'b0;
    case (idx)
      0: begin e.base = 16'h4000; e.limit = 15'h0800; e.ronly = 1'b1; end
      1: begin e.base = 16'h4800; e.limit = 15'h1400; end
      2: begin e.base = 16'hF000; e.limit = 15'h1000; end
      default: begin e.base = 16'h0000; e.limit = 15'h3000; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kernel,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_entry_t       wr_entry,
  input  logic [SEG_W-1:0] rd_idx,
  output seg_entry_t       rd_entry
);
  seg_entry_t [N_SEG-1:0] tbl_q;
  seg_entry_t [N_SEG-1:0] tbl_d;
  logic                   wr_ok;

  assign wr_ok = wr_en & wr_kernel;

  always_comb begin
    tbl_d = tbl_q;
    if (wr_ok) tbl_d[wr_idx] = wr_entry;
  end

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q[g] <= seg_reset_entry(g);
      else if (wr_ok)  tbl_q[g] <= tbl_d[g];
    end
  end

  assign rd_entry = tbl_q[rd_idx];

  assert_user_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_kernel) |=> $stable(tbl_q));

  assert_kernel_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kernel) |=> (tbl_q[$past(wr_idx)] == $past(wr_entry)));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
(
  input  seg_entry_t        entry,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_write,
  output fault_e            fault,
  output logic [ADDR_W-1:0] paddr
);
  logic              oob;
  logic [ADDR_W-1:0] sum;

  assign oob = ({1'b0, offset} >= entry.limit);
  assign sum = entry.base + ADDR_W'(offset);

  always_comb begin
    if (!entry.valid)                 fault = FLT_INVALID;
    else if (oob)                     fault = FLT_BOUNDS;
    else if (is_write && entry.ronly) fault = FLT_PROT;
    else                              fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? sum : '0;
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [15:0] req_vaddr,
  input  logic        req_write,
  input  logic        cfg_we,
  input  logic        cfg_kernel,
  input  logic [1:0]  cfg_idx,
  input  logic [15:0] cfg_base,
  input  logic [14:0] cfg_limit,
  input  logic        cfg_valid,
  input  logic        cfg_ronly,
  output logic        rsp_valid,
  output logic [15:0] rsp_paddr,
  output logic [1:0]  rsp_fault,
  output logic        rsp_mem_en
);
  logic [1:0]  rst_sync;
  logic        rst_ni;
  seg_entry_t  wr_entry;
  seg_entry_t  rd_entry;
  fault_e      chk_fault;
  logic [ADDR_W-1:0] chk_paddr;

  logic              valid_d, mem_en_d;
  logic [ADDR_W-1:0] paddr_d;
  logic [1:0]        fault_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign wr_entry = '{base: cfg_base, limit: cfg_limit, valid: cfg_valid, ronly: cfg_ronly};

  seg_table u_table (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (cfg_we),
    .wr_kernel (cfg_kernel),
    .wr_idx    (cfg_idx),
    .wr_entry  (wr_entry),
    .rd_idx    (req_vaddr[ADDR_W-1 -: SEG_W]),
    .rd_entry  (rd_entry)
  );

  seg_check u_check (
    .entry    (rd_entry),
    .offset   (req_vaddr[OFF_W-1:0]),
    .is_write (req_write),
    .fault    (chk_fault),
    .paddr    (chk_paddr)
  );

  always_comb begin
    valid_d  = req_valid;
    paddr_d  = req_valid ? chk_paddr : '0;
    fault_d  = req_valid ? chk_fault : FLT_NONE;
    mem_en_d = req_valid && (chk_fault == FLT_NONE);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= 2'd0;
      rsp_mem_en <= 1'b0;
    end else begin
      rsp_valid  <= valid_d;
      rsp_paddr  <= paddr_d;
      rsp_fault  <= fault_d;
      rsp_mem_en <= mem_en_d;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> (!rsp_valid && !rsp_mem_en && rsp_paddr == '0));

  assert_fault_blocks_access_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_fault != 2'd0) |-> (!rsp_mem_en && rsp_paddr == '0));

  assert_clean_rsp_enables_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_mem_en);

  assert_store_readonly_faults_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_write && rd_entry.valid && rd_entry.ronly &&
     ({1'b0, req_vaddr[OFF_W-1:0]} < rd_entry.limit)) |=> (rsp_fault == 2'd3));
endmodule

// File: tb/seg_xlat_unit_tb.sv
module seg_xlat_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_vaddr;
  logic        cfg_we, cfg_kernel, cfg_valid, cfg_ronly;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic [14:0] cfg_limit;
  logic        rsp_valid, rsp_mem_en;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] m_base [4];
  logic [14:0] m_lim  [4];
  logic        m_val  [4];
  logic        m_ro   [4];

  always #5 clk = ~clk;

  seg_xlat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .cfg_we(cfg_we), .cfg_kernel(cfg_kernel),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_valid(cfg_valid), .cfg_ronly(cfg_ronly), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_mem_en(rsp_mem_en)
  );

  function automatic logic [1:0] exp_fault(input logic [15:0] va, input logic wr);
    int s = int'(va[15:14]);
    if (!m_val[s])                         return 2'd1;
    if ({1'b0, va[13:0]} >= m_lim[s])      return 2'd2;
    if (wr && m_ro[s])                     return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_paddr(input logic [15:0] va, input logic wr);
    if (exp_fault(va, wr) != 2'd0) return 16'h0;
    return m_base[int'(va[15:14])] + {2'b00, va[13:0]};
  endfunction

  task automatic model_reset();
    m_base[0] = 16'h4000; m_lim[0] = 15'h0800; m_val[0] = 1; m_ro[0] = 1;
    m_base[1] = 16'h4800; m_lim[1] = 15'h1400; m_val[1] = 1; m_ro[1] = 0;
    m_base[2] = 16'hF000; m_lim[2] = 15'h1000; m_val[2] = 1; m_ro[2] = 0;
    m_base[3] = 16'h0000; m_lim[3] = 15'h3000; m_val[3] = 1; m_ro[3] = 0;
  endtask

  task automatic check(input string tag, input logic v, input logic [15:0] pa,
                       input logic [1:0] f, input logic me);
    total++;
    if (rsp_valid !== v || rsp_paddr !== pa || rsp_fault !== f || rsp_mem_en !== me) begin
      bad++;
      $display("FAIL %s: got v=%0b pa=%h f=%0d me=%0b exp v=%0b pa=%h f=%0d me=%0b",
               tag, rsp_valid, rsp_paddr, rsp_fault, rsp_mem_en, v, pa, f, me);
    end
  endtask

  // Called at a negedge; drives, steps one clock, checks at the next negedge.
  task automatic cycle(input string tag, input logic rv, input logic [15:0] va,
                       input logic wr, input logic we, input logic kern,
                       input logic [1:0] idx, input logic [15:0] b,
                       input logic [14:0] l, input logic vf, input logic ro);
    logic [15:0] epa;
    logic [1:0]  ef;
    req_valid = rv; req_vaddr = va; req_write = wr;
    cfg_we = we; cfg_kernel = kern; cfg_idx = idx; cfg_base = b;
    cfg_limit = l; cfg_valid = vf; cfg_ronly = ro;
    epa = rv ? exp_paddr(va, wr) : 16'h0;
    ef  = rv ? exp_fault(va, wr) : 2'd0;
    @(posedge clk);
    if (we && kern) begin
      m_base[idx] = b; m_lim[idx] = l; m_val[idx] = vf; m_ro[idx] = ro;
    end
    @(negedge clk);
    check(tag, rv, epa, ef, rv && ef == 2'd0);
  endtask

  task automatic rd(input string tag, input logic [15:0] va, input logic wr);
    cycle(tag, 1'b1, va, wr, 1'b0, 1'b0, 2'd0, 16'h0, 15'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = 0; req_write = 0;
    cfg_we = 0; cfg_kernel = 0; cfg_idx = 0; cfg_base = 0;
    cfg_limit = 0; cfg_valid = 0; cfg_ronly = 0;
    model_reset();
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    check("R10 in reset", 0, 16'h0, 2'd0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 after reset", 0, 16'h0, 2'd0, 0);

    // R1 / R7 directed translations against the reset table
    rd("R1 R7 code 0x0240", 16'h0240, 0);
    if (rsp_paddr !== 16'h4240) begin bad++; $display("FAIL R1: pa=%h exp 4240", rsp_paddr); end
    total++;
    rd("R1 R7 data 0x4050", 16'h4050, 0);
    if (rsp_paddr !== 16'h4850) begin bad++; $display("FAIL R1: pa=%h exp 4850", rsp_paddr); end
    total++;
    rd("R7 seg2 top byte", 16'h8FFF, 1);
    rd("R7 seg3 base zero store", 16'hC000, 1);
    rd("R3 seg0 at limit", 16'h0800, 0);
    rd("R3 seg0 last byte", 16'h07FF, 0);
    rd("R3 seg3 at limit", 16'hF000, 0);
    rd("R5 store to read-only", 16'h0100, 1);
    rd("R5 bounds beats prot", 16'h0900, 1);
    rd("R5 store read-write", 16'h5000, 1);
    cycle("R2 idle", 0, 16'h4050, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9 user write ignored, then observe segment 1 unchanged
    cycle("R9 user write", 0, 0, 0, 1, 0, 2'd1, 16'h1234, 15'h0010, 1'b0, 1'b1);
    rd("R9 seg1 unchanged", 16'h4050, 1);
    // R8 kernel write with same-cycle request seeing old entry
    cycle("R8 write same cycle", 1, 16'h4050, 0, 1, 1, 2'd1, 16'h1000, 15'h0040, 1'b0, 1'b0);
    rd("R4 invalid beats bounds", 16'h7FFF, 1);
    rd("R4 invalid seg1", 16'h4000, 0);
    cycle("R8 truncation entry", 0, 0, 0, 1, 1, 2'd2, 16'hFF00, 15'h4000, 1'b1, 1'b0);
    rd("R1 wrap to 16 bits", 16'hBFFF, 0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] va;
      logic        rv, wr, we, kn, vf, ro;
      logic [1:0]  ix;
      logic [15:0] b;
      logic [14:0] l;
      va = 16'($urandom);
      rv = ($urandom % 8) != 0;
      wr = 1'($urandom);
      we = ($urandom % 6) == 0;
      kn = 1'($urandom);
      ix = 2'($urandom);
      b  = 16'($urandom);
      l  = 15'($urandom % 16'h4001);
      vf = ($urandom % 5) != 0;
      ro = 1'($urandom);
      cycle("R1-mix random", rv, va, wr, we, kn, ix, b, l, vf, ro);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule